// File: doc/BRIEF.md
# Shift, Align and Sign-Extend Unit

This unit sits next to the ALU of a 32-bit big-endian datapath and folds three small jobs into one piece of logic. It is a barrel shifter for logical left, logical right and arithmetic right shifts. It is the load aligner that picks a byte or halfword out of the word returned by memory and zero- or sign-extends it. It is the store placer that puts store data on the right byte lanes and raises the matching lane enables. It also forms the two immediate values the instruction set needs: the sign-extended 16-bit immediate, and the immediate moved into the upper half of the word.

One operation code selects the job. The `amt_i` input carries the shift amount for shifts and the low address bits for loads and stores. Byte offset 0 is the most significant byte of the word. An optional output register, on by default, holds the result, the lane enables and an alignment-error flag. With the register on, every result appears one clock after its inputs.

Top module: `shift_align_unit`

## Requirements
- R1: Op 0 shifts `opnd_i` left logically, op 1 shifts it right logically, and op 2 shifts it right arithmetically, filling with bit 31. All three shift by `amt_i[4:0]`.
- R2: A shift by an amount of 0 returns `opnd_i` unchanged for ops 0, 1 and 2.
- R3: Byte loads use op 3 (signed) and op 4 (unsigned). Offset k = `amt_i[1:0]` selects bits [31-8k:24-8k] of `opnd_i`. The signed form extends from bit 7 of that byte and the unsigned form zero-extends it.
- R4: Halfword loads use op 5 (signed) and op 6 (unsigned). `amt_i[1]`=0 selects bits [31:16] and `amt_i[1]`=1 selects bits [15:0]. The signed form extends from bit 15 and the unsigned form zero-extends.
- R5: A word load (op 7) returns `opnd_i`. Every op that is not a store drives `lane_en_o` to 0000.
- R6: A byte store (op 8) copies `opnd_i[7:0]` into all four byte lanes. `lane_en_o` is 1000 shifted right by the offset, so offset 0 gives 1000 and offset 3 gives 0001.
- R7: A halfword store (op 9) copies `opnd_i[15:0]` into both halves. `lane_en_o` is 1100 when `amt_i[1]`=0 and 0011 when it is 1.
- R8: A word store (op 10) passes `opnd_i` through with `lane_en_o` = 1111.
- R9: `misalign_o` is 1 for a halfword access (ops 5, 6, 9) with `amt_i[0]`=1, and for a word access (ops 7, 10) with `amt_i[1:0]`≠0. For every other case it is 0. A misaligned store drives `lane_en_o` = 0000, and the result of a misaligned access is not specified.
- R10: Op 11 returns `imm_i` sign-extended to 32 bits. Op 12 returns `{imm_i, 16'h0000}`.
- R11: With OUT_REG=1, the outputs show the result of the inputs present at the previous rising clock edge. While `rst` is high at an edge, all outputs are cleared to zero.
- R12: The unused op codes 13 to 15 give a zero result, zero lane enables and no alignment error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| opnd_i | input | 32 | Operand: shift source, loaded word or store data |
| amt_i | input | 5 | Shift amount, or address low bits in [1:0] |
| imm_i | input | 16 | Instruction immediate |
| res_o | output | 32 | Result word |
| lane_en_o | output | 4 | Byte-lane enables, bit 3 = offset 0 |
| misalign_o | output | 1 | Halfword or word address not aligned |

## Verification
The hardest cases to reach are the ones where several fields have to line up at once. One is an arithmetic shift of a negative word by the full amount of 31, which must produce all ones. Another is a signed sub-word load whose selected byte or halfword has its top bit set while the neighbouring bytes carry the opposite pattern, so that picking the wrong lane or the wrong sign bit becomes visible. Uniform random operands hit these cases rarely, so directed vectors cover them first. After that, random operations run with random offsets over all 32 shift amounts, including the misaligned offsets and the unused op codes.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [3:0] {
        OP_SLL  = 4'd0,
        OP_SRL  = 4'd1,
        OP_SRA  = 4'd2,
        OP_LDB  = 4'd3,
        OP_LDBU = 4'd4,
        OP_LDH  = 4'd5,
        OP_LDHU = 4'd6,
        OP_LDW  = 4'd7,
        OP_STB  = 4'd8,
        OP_STH  = 4'd9,
        OP_STW  = 4'd10,
        OP_IMMS = 4'd11,
        OP_IMMH = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    function automatic size_e size_of(op_e op);
        case (op)
            OP_LDB, OP_LDBU, OP_STB: return SZ_BYTE;
            OP_LDH, OP_LDHU, OP_STH: return SZ_HALF;
            default:                 return SZ_WORD;
        endcase
    endfunction

    function automatic logic is_signed_load(op_e op);
        return (op == OP_LDB) || (op == OP_LDH);
    endfunction

endpackage

// File: rtl/sau_shifter.sv
module sau_shifter #(
    parameter int DATA_W = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  d_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic               left_i,
    input  logic               arith_i,
    output logic [DATA_W-1:0]  q_o
);
    localparam logic [DATA_W-1:0] ALL1 = '1;

    logic [SHAMT_W:0][DATA_W-1:0] stg;
    logic fill;

    assign fill   = arith_i & d_i[DATA_W-1];
    assign stg[0] = d_i;

    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        localparam int DIST = 1 << i;
        logic [DATA_W-1:0] moved;
        always_comb begin
            if (left_i)
                moved = stg[i] << DIST;
            else
                moved = (stg[i] >> DIST) | (fill ? ~(ALL1 >> DIST) : '0);
        end
        assign stg[i+1] = amt_i[i] ? moved : stg[i];
    end

    assign q_o = stg[SHAMT_W];
endmodule

// File: rtl/sau_load_align.sv
module sau_load_align
    import sau_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int HALVES = LANES / 2
) (
    input  logic [DATA_W-1:0] d_i,
    input  logic [OFF_W-1:0]  off_i,
    input  size_e             size_i,
    input  logic              sgn_i,
    output logic [DATA_W-1:0] q_o,
    output logic              misalign_o
);
    logic [7:0]  byte_v;
    logic [15:0] half_v;
    logic [OFF_W-2:0] hidx;

    assign hidx   = off_i[OFF_W-1:1];
    assign byte_v = d_i[(LANES-1-int'(off_i))*8 +: 8];
    assign half_v = d_i[(HALVES-1-int'(hidx))*16 +: 16];

    always_comb begin
        q_o        = d_i;
        misalign_o = 1'b0;
        case (size_i)
            SZ_BYTE: q_o = {{(DATA_W-8){sgn_i & byte_v[7]}}, byte_v};
            SZ_HALF: begin
                q_o        = {{(DATA_W-16){sgn_i & half_v[15]}}, half_v};
                misalign_o = off_i[0];
            end
            default: misalign_o = |off_i;
        endcase
    end
endmodule

// File: rtl/sau_store_place.sv
module sau_store_place
    import sau_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] d_i,
    input  logic [OFF_W-1:0]  off_i,
    input  size_e             size_i,
    output logic [DATA_W-1:0] q_o,
    output logic [LANES-1:0]  lanes_o,
    output logic              misalign_o
);
    localparam logic [LANES-1:0] TOP1 = LANES'(1) << (LANES-1);
    localparam logic [LANES-1:0] TOP2 = LANES'(3) << (LANES-2);

    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                q_o        = {LANES{d_i[7:0]}};
                misalign_o = 1'b0;
                lanes_o    = TOP1 >> off_i;
            end
            SZ_HALF: begin
                q_o        = {(LANES/2){d_i[15:0]}};
                misalign_o = off_i[0];
                lanes_o    = misalign_o ? '0 : (TOP2 >> off_i);
            end
            default: begin
                q_o        = d_i;
                misalign_o = |off_i;
                lanes_o    = misalign_o ? '0 : '1;
            end
        endcase
    end
endmodule

// File: rtl/shift_align_unit.sv
module shift_align_unit
    import sau_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter bit OUT_REG = 1'b1,
    localparam int SHAMT_W = $clog2(DATA_W),
    localparam int LANES   = DATA_W / 8,
    localparam int OFF_W   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         op_i,
    input  logic [DATA_W-1:0]  opnd_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic [IMM_W-1:0]   imm_i,
    output logic [DATA_W-1:0]  res_o,
    output logic [LANES-1:0]   lane_en_o,
    output logic               misalign_o
);
    op_e   op;
    size_e sz;
    logic [OFF_W-1:0] off;

    assign op  = op_e'(op_i);
    assign sz  = size_of(op);
    assign off = amt_i[OFF_W-1:0];

    logic [DATA_W-1:0] shf_q, ld_q, st_q;
    logic [LANES-1:0]  st_lanes;
    logic              ld_mis, st_mis;

    sau_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shf (
        .d_i(opnd_i), .amt_i(amt_i),
        .left_i(op == OP_SLL), .arith_i(op == OP_SRA), .q_o(shf_q)
    );

    sau_load_align #(.DATA_W(DATA_W)) u_ld (
        .d_i(opnd_i), .off_i(off), .size_i(sz), .sgn_i(is_signed_load(op)),
        .q_o(ld_q), .misalign_o(ld_mis)
    );

    sau_store_place #(.DATA_W(DATA_W)) u_st (
        .d_i(opnd_i), .off_i(off), .size_i(sz),
        .q_o(st_q), .lanes_o(st_lanes), .misalign_o(st_mis)
    );

    logic [DATA_W-1:0] res_c;
    logic [LANES-1:0]  lane_c;
    logic              mis_c;

    always_comb begin
        res_c  = '0;
        lane_c = '0;
        mis_c  = 1'b0;
        case (op)
            OP_SLL, OP_SRL, OP_SRA: res_c = shf_q;
            OP_LDB, OP_LDBU, OP_LDH, OP_LDHU, OP_LDW: begin
                res_c = ld_q;
                mis_c = ld_mis;
            end
            OP_STB, OP_STH, OP_STW: begin
                res_c  = st_q;
                lane_c = st_lanes;
                mis_c  = st_mis;
            end
            OP_IMMS: res_c = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
            OP_IMMH: res_c = {imm_i, {(DATA_W-IMM_W){1'b0}}};
            default: ;
        endcase
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_o      <= '0;
                lane_en_o  <= '0;
                misalign_o <= 1'b0;
            end else begin
                res_o      <= res_c;
                lane_en_o  <= lane_c;
                misalign_o <= mis_c;
            end
        end
    end else begin : g_comb
        assign res_o      = res_c;
        assign lane_en_o  = lane_c;
        assign misalign_o = mis_c;
    end

    p_zero_amt_r2: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_SLL || op == OP_SRL || op == OP_SRA) && amt_i == '0) |-> (shf_q == opnd_i));

    p_sra_sign_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SRA) |-> (shf_q[DATA_W-1] == opnd_i[DATA_W-1]));

    p_byte_lane_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STB) |-> ($countones(lane_c) == 1));

    p_mis_nolane_r9: assert property (@(posedge clk) disable iff (rst)
        mis_c |-> (lane_c == '0));

    p_immh_low_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IMMH) |-> (res_c[DATA_W-IMM_W-1:0] == '0));

    p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
        !(op == OP_STB || op == OP_STH || op == OP_STW) |-> (lane_c == '0));

    if (OUT_REG) begin : g_reg_chk
        p_reset_clear_r11: assert property (@(posedge clk)
            rst |=> (res_o == '0 && lane_en_o == '0 && !misalign_o));
    end
endmodule

// File: tb/sim_shift_align_unit.sv
module sim_shift_align_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [31:0] opnd_i = '0;
    logic [4:0]  amt_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] res_o;
    logic [3:0]  lane_en_o;
    logic        misalign_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shift_align_unit u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .opnd_i(opnd_i), .amt_i(amt_i),
        .imm_i(imm_i), .res_o(res_o), .lane_en_o(lane_en_o), .misalign_o(misalign_o)
    );

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2: return "R1";
            4'd3, 4'd4:       return "R3";
            4'd5, 4'd6:       return "R4";
            4'd7:             return "R5";
            4'd8:             return "R6";
            4'd9:             return "R7";
            4'd10:            return "R8";
            4'd11, 4'd12:     return "R10";
            default:          return "R12";
        endcase
    endfunction

    // returns {misalign, lanes[3:0], result[31:0]}
    function automatic logic [36:0] model(logic [3:0] op, logic [31:0] d,
                                          logic [4:0] a, logic [15:0] im);
        logic [31:0] r;
        logic [3:0]  l;
        logic        m;
        logic [7:0]  b;
        logic [15:0] h;
        r = 32'h0; l = 4'h0; m = 1'b0;
        case (a[1:0])
            2'd0: b = d[31:24];
            2'd1: b = d[23:16];
            2'd2: b = d[15:8];
            default: b = d[7:0];
        endcase
        h = a[1] ? d[15:0] : d[31:16];
        case (op)
            4'd0: r = d << a;
            4'd1: r = d >> a;
            4'd2: r = 32'($signed(d) >>> a);
            4'd3: r = {{24{b[7]}}, b};
            4'd4: r = {24'h0, b};
            4'd5: begin r = {{16{h[15]}}, h}; m = a[0]; end
            4'd6: begin r = {16'h0, h}; m = a[0]; end
            4'd7: begin r = d; m = (a[1:0] != 2'd0); end
            4'd8: begin
                r = {4{d[7:0]}};
                case (a[1:0])
                    2'd0: l = 4'b1000;
                    2'd1: l = 4'b0100;
                    2'd2: l = 4'b0010;
                    default: l = 4'b0001;
                endcase
            end
            4'd9: begin
                r = {2{d[15:0]}}; m = a[0];
                l = m ? 4'b0000 : (a[1] ? 4'b0011 : 4'b1100);
            end
            4'd10: begin
                r = d; m = (a[1:0] != 2'd0);
                l = m ? 4'b0000 : 4'b1111;
            end
            4'd11: r = {{16{im[15]}}, im};
            4'd12: r = {im, 16'h0};
            default: ;
        endcase
        return {m, l, r};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic apply(logic [3:0] op, logic [31:0] d, logic [4:0] a,
                         logic [15:0] im, string tag);
        logic [36:0] e;
        e = model(op, d, a, im);
        @(negedge clk);
        op_i = op; opnd_i = d; amt_i = a; imm_i = im;
        @(posedge clk);
        #1;
        chk(tag, "misalign", {31'h0, misalign_o}, {31'h0, e[36]});
        chk(tag, "lanes", {28'h0, lane_en_o}, {28'h0, e[35:32]});
        if (!e[36]) chk(tag, "result", res_o, e[31:0]);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R11: reset clears outputs even with active inputs
        op_i = 4'd10; opnd_i = 32'hDEADBEEF; amt_i = 5'd3;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset result", res_o, 32'h0);
        chk("R11", "reset lanes", {28'h0, lane_en_o}, 32'h0);
        chk("R11", "reset misalign", {31'h0, misalign_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        apply(4'd0, 32'h0000_0001, 5'd31, 16'h0, "R1");
        apply(4'd2, 32'h8000_0000, 5'd31, 16'h0, "R1");
        apply(4'd1, 32'h8000_0000, 5'd31, 16'h0, "R1");
        apply(4'd2, 32'h7F00_0000, 5'd4,  16'h0, "R1");
        apply(4'd0, 32'hA5C3_0F96, 5'd0,  16'h0, "R2");
        apply(4'd2, 32'hA5C3_0F96, 5'd0,  16'h0, "R2");
        apply(4'd3, 32'h8012_3456, 5'd0,  16'h0, "R3");
        apply(4'd3, 32'h7F80_7F80, 5'd1,  16'h0, "R3");
        apply(4'd4, 32'h1234_56F6, 5'd3,  16'h0, "R3");
        apply(4'd5, 32'h8001_7FFF, 5'd0,  16'h0, "R4");
        apply(4'd5, 32'h7FFF_8001, 5'd2,  16'h0, "R4");
        apply(4'd6, 32'h7FFF_8001, 5'd2,  16'h0, "R4");
        apply(4'd7, 32'hCAFE_F00D, 5'd0,  16'h0, "R5");
        apply(4'd8, 32'h1234_56A5, 5'd0,  16'h0, "R6");
        apply(4'd8, 32'h1234_56A5, 5'd2,  16'h0, "R6");
        apply(4'd8, 32'h1234_56A5, 5'd3,  16'h0, "R6");
        apply(4'd9, 32'h1234_BEEF, 5'd0,  16'h0, "R7");
        apply(4'd9, 32'h1234_BEEF, 5'd2,  16'h0, "R7");
        apply(4'd10, 32'h0BAD_F00D, 5'd0, 16'h0, "R8");
        apply(4'd5, 32'h1234_5678, 5'd1,  16'h0, "R9");
        apply(4'd9, 32'h1234_5678, 5'd3,  16'h0, "R9");
        apply(4'd10, 32'h1234_5678, 5'd2, 16'h0, "R9");
        apply(4'd7, 32'h1234_5678, 5'd1,  16'h0, "R9");
        apply(4'd11, 32'h0, 5'd0, 16'h8000, "R10");
        apply(4'd11, 32'h0, 5'd0, 16'h7FFF, "R10");
        apply(4'd12, 32'hFFFF_FFFF, 5'd0, 16'h1234, "R10");
        apply(4'd13, 32'hFFFF_FFFF, 5'd3, 16'hFFFF, "R12");
        apply(4'd15, 32'hFFFF_FFFF, 5'd1, 16'hFFFF, "R12");

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            apply(op, $urandom, 5'($urandom), 16'($urandom), tag_of(op));
        end

        // R11: reset asserted mid-run clears outputs again
        @(negedge clk);
        rst = 1'b1; op_i = 4'd8; opnd_i = 32'hFF;
        @(posedge clk);
        #1;
        chk("R11", "mid-run reset result", res_o, 32'h0);
        chk("R11", "mid-run reset lanes", {28'h0, lane_en_o}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule